// File: doc/BRIEF.md
# Paired-byte event UART transmitter

This block turns capture events from a smart-card line sniffer into fixed-size messages for a host computer. Two kinds of event enter it: a captured character, delivered with its data byte, parity bit, start-bit sample, error-signal flag and three flags from the speed-negotiation tracker; and any change of level on the synchronized card reset line, which the block detects itself. Each event becomes one 16-bit status word.

Every word leaves on a single serial line as two 8N1 bytes shifted out back to back, as one 20-bit frame with no gap inside it. The host therefore only ever sees pairs, and after a long pause it can discard a half-received pair to regain alignment. A small queue holds events while a frame is on the line. A character is only admitted while at least two entries are free, so the last entry is always kept for a reset-line event.

Top module: `evt_pair_uart`

## Requirements
- R1: The serial output is high while reset is held, and it stays high whenever no frame is being sent.
- R2: A character event gives the word {bit15=0, bit14=1, bit13=speed-enhanced flag, bit12=final-check-byte position flag, bit11=first-parameter-byte position flag, bit10=error-signal flag, bit9=start-bit sample, bit8=parity bit, bits7:0=data byte}.
- R3: Every change of the reset line, rising or falling, gives the word {bit15=1, bit14=new line level, bits13:0=0}. The line level that the block compares against after reset is low.
- R4: Each word is sent as a 20-bit frame: start bit (0), bits 7:0 LSB first, stop bit (1), start bit (0), bits 15:8 LSB first, stop bit (1). Each bit lasts BAUD_DIV clocks and there is no idle time between the two bytes.
- R5: When the transmitter is idle and the queue is empty, the start bit of the frame for an event sampled at clock edge E begins at edge E+1.
- R6: Queued words are sent in arrival order. A frame that waits in the queue starts exactly 20*BAUD_DIV+1 clocks after the start of the frame before it.
- R7: A character event is accepted only when the queue holds no more than DEPTH-2 entries, counted before that cycle's removal. Otherwise it is dropped.
- R8: A reset-line event is accepted whenever the queue is not full. A character event in the same cycle as a reset-line event is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| char_valid | input | 1 | One-cycle pulse: a character was captured |
| char_data | input | 8 | Captured data byte |
| char_parity | input | 1 | Received parity bit |
| char_start_smp | input | 1 | Line value sampled at the start-bit midpoint |
| char_err | input | 1 | Error signal was seen after the character |
| char_fast | input | 1 | Character was captured in a speed-enhanced mode |
| char_pck_pos | input | 1 | Character sits at the expected final check byte of the card's negotiation reply |
| char_pps1_pos | input | 1 | Character sits at the expected first parameter byte of the card's negotiation reply |
| sim_rst | input | 1 | Card reset line, already synchronized to clk |
| tx_out | output | 1 | Serial data line to the host |

## Verification
An event sampled at edge E is pushed into the queue at E and loaded into the shifter at E+1. The start bit is therefore on the line from E+1 onward, and bit k of the frame fills clocks E+1+k*BAUD_DIV up to the next bit. The bench drives inputs on falling edges and keeps a posedge counter. Its monitor detects the start bit half a clock after it begins, takes one sample every BAUD_DIV clocks, checks that the start counter is exactly two posedges after the drive point, and checks that queued frames begin exactly 20*BAUD_DIV+1 clocks apart. Drop behaviour is checked by counting the frames that reach the line against the frames the bench predicts.

// File: rtl/evt_tx_pkg.sv
// Shared widths and word/frame builders for the paired-byte event transmitter.
// Assumes: word layout as stated in the brief; the frame is always 20 bits.
package evt_tx_pkg;
    localparam int WORD_W  = 16;
    localparam int FRAME_W = 20;

    // Builds the status word for a captured character.
    function automatic logic [WORD_W-1:0] pack_char(
        input logic       fast,
        input logic       pck,
        input logic       pps1,
        input logic       err,
        input logic       smp,
        input logic       par,
        input logic [7:0] data
    );
        return {1'b0, 1'b1, fast, pck, pps1, err, smp, par, data};
    endfunction

    // Builds the status word for a reset-line level change.
    function automatic logic [WORD_W-1:0] pack_rst(input logic level);
        return {1'b1, level, 14'd0};
    endfunction

    // Lays a word out as two 8N1 bytes, the low byte first; bit 0 goes out first.
    function automatic logic [FRAME_W-1:0] frame_of(input logic [WORD_W-1:0] w);
        return {1'b1, w[15:8], 1'b0, 1'b1, w[7:0], 1'b0};
    endfunction
endpackage

// File: rtl/evt_word_pack.sv
// Event packer: finds reset-line edges, builds status words and decides which
// word, if any, enters the queue this cycle.
// Assumes: sim_rst is already synchronous to clk; at most one push per cycle;
// fifo_count is the registered occupancy, before this cycle's removal.
module evt_word_pack
    import evt_tx_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_valid,
    input  logic [7:0]        char_data,
    input  logic              char_parity,
    input  logic              char_start_smp,
    input  logic              char_err,
    input  logic              char_fast,
    input  logic              char_pck_pos,
    input  logic              char_pps1_pos,
    input  logic              sim_rst,
    input  logic [CNT_W-1:0]  fifo_count,
    output logic              push,
    output logic [WORD_W-1:0] push_word
);
    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CHAR_LVL = CNT_W'(DEPTH - 2);

    logic rst_q;
    logic rst_edge;

    // Holds the last seen reset-line level; low after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_q <= 1'b0;
        else        rst_q <= sim_rst;
    end

    assign rst_edge = sim_rst ^ rst_q;

    // Picks the word to queue: a reset-line event first, a character only with two free entries.
    always_comb begin
        push      = 1'b0;
        push_word = '0;
        if (rst_edge) begin
            if (fifo_count < FULL_LVL) begin
                push      = 1'b1;
                push_word = pack_rst(sim_rst);
            end
        end else if (char_valid && fifo_count <= CHAR_LVL) begin
            push      = 1'b1;
            push_word = pack_char(char_fast, char_pck_pos, char_pps1_pos,
                                  char_err, char_start_smp, char_parity, char_data);
        end
    end

    // R7
    char_reserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !push_word[15]) |-> (fifo_count <= CHAR_LVL));

    // R3
    rst_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && push_word[15]) |-> (push_word[13:0] == 14'd0 && push_word[14] != rst_q));
endmodule

// File: rtl/evt_fifo.sv
// Small word queue with registered occupancy.
// Assumes: push is never raised when full unless pop is raised too; pop only when not empty.
module evt_fifo
    import evt_tx_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] push_word,
    input  logic              pop,
    output logic [WORD_W-1:0] pop_word,
    output logic              empty,
    output logic [CNT_W-1:0]  count
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    // Writes the incoming word into storage.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_word;
    end

    // Advances the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign pop_word = mem[rd_ptr];
    assign empty    = (count == '0);

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && !pop && count == CNT_W'(DEPTH)));

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop && empty));
endmodule

// File: rtl/pair_uart_tx.sv
// Paired-byte serial shifter: loads one word and sends it as a single 20-bit
// frame, with each bit held for BAUD_DIV clocks.
// Assumes: BAUD_DIV >= 2; the word is stable at the pop request.
module pair_uart_tx
    import evt_tx_pkg::*;
#(
    parameter int BAUD_DIV = 104,
    localparam int BAUD_W = $clog2(BAUD_DIV + 1),
    localparam int BIT_W  = $clog2(FRAME_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              avail,
    input  logic [WORD_W-1:0] word,
    output logic              pop,
    output logic              tx_out
);
    localparam logic [BAUD_W-1:0] BAUD_LAST = BAUD_W'(BAUD_DIV - 1);
    localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(FRAME_W - 1);

    logic               busy;
    logic [BAUD_W-1:0]  baud_cnt;
    logic [BIT_W-1:0]   bit_idx;
    logic [FRAME_W-1:0] shreg;

    assign pop    = !busy && avail;
    assign tx_out = shreg[0];

    // Loads a frame when idle, then shifts one bit out every BAUD_DIV clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            baud_cnt <= '0;
            bit_idx  <= '0;
            shreg    <= '1;
        end else if (pop) begin
            busy     <= 1'b1;
            baud_cnt <= '0;
            bit_idx  <= '0;
            shreg    <= frame_of(word);
        end else if (busy) begin
            if (baud_cnt == BAUD_LAST) begin
                baud_cnt <= '0;
                shreg    <= {1'b1, shreg[FRAME_W-1:1]};
                if (bit_idx == BIT_LAST) busy <= 1'b0;
                else                     bit_idx <= bit_idx + 1'b1;
            end else begin
                baud_cnt <= baud_cnt + 1'b1;
            end
        end
    end

    // R5
    frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> !tx_out);

    // R1
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_out);

    // R4
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pop && baud_cnt != BAUD_LAST) |=> $stable(tx_out));
endmodule

// File: rtl/evt_pair_uart.sv
// Top level: event packer, word queue and paired-byte serial shifter.
// Assumes: sim_rst is synchronized upstream; char_valid is a one-cycle pulse.
module evt_pair_uart
    import evt_tx_pkg::*;
#(
    parameter int BAUD_DIV = 104,
    parameter int DEPTH    = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       char_valid,
    input  logic [7:0] char_data,
    input  logic       char_parity,
    input  logic       char_start_smp,
    input  logic       char_err,
    input  logic       char_fast,
    input  logic       char_pck_pos,
    input  logic       char_pps1_pos,
    input  logic       sim_rst,
    output logic       tx_out
);
    logic              push;
    logic [WORD_W-1:0] push_word;
    logic              pop;
    logic [WORD_W-1:0] pop_word;
    logic              empty;
    logic [CNT_W-1:0]  count;

    evt_word_pack #(.DEPTH(DEPTH)) u_pack (
        .clk            (clk),
        .rst_n          (rst_n),
        .char_valid     (char_valid),
        .char_data      (char_data),
        .char_parity    (char_parity),
        .char_start_smp (char_start_smp),
        .char_err       (char_err),
        .char_fast      (char_fast),
        .char_pck_pos   (char_pck_pos),
        .char_pps1_pos  (char_pps1_pos),
        .sim_rst        (sim_rst),
        .fifo_count     (count),
        .push           (push),
        .push_word      (push_word)
    );

    evt_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_word (push_word),
        .pop       (pop),
        .pop_word  (pop_word),
        .empty     (empty),
        .count     (count)
    );

    pair_uart_tx #(.BAUD_DIV(BAUD_DIV)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .avail  (!empty),
        .word   (pop_word),
        .pop    (pop),
        .tx_out (tx_out)
    );
endmodule

// File: tb/evt_pair_uart_tb.sv
module evt_pair_uart_tb;
    localparam int DIV   = 4;
    localparam int DEPTH = 4;
    localparam int GAP   = 20 * DIV + 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       char_valid = 1'b0;
    logic [7:0] char_data = '0;
    logic       char_parity = 1'b0, char_start_smp = 1'b0, char_err = 1'b0;
    logic       char_fast = 1'b0, char_pck_pos = 1'b0, char_pps1_pos = 1'b0;
    logic       sim_rst = 1'b0;
    logic       tx_out;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 0;

    logic [15:0] exp_word [0:511];
    int          exp_n = 0;
    int          rx_n = 0;
    int          start_cyc [0:511];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    evt_pair_uart #(.BAUD_DIV(DIV), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_data(char_data),
        .char_parity(char_parity), .char_start_smp(char_start_smp), .char_err(char_err),
        .char_fast(char_fast), .char_pck_pos(char_pck_pos), .char_pps1_pos(char_pps1_pos),
        .sim_rst(sim_rst), .tx_out(tx_out)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    // Serial monitor: finds the start bit, samples 20 bits BAUD_DIV clocks apart.
    initial begin
        logic [19:0] bits;
        logic [15:0] w;
        forever begin
            @(negedge clk);
            if (rst_n && tx_out === 1'b0) begin
                start_cyc[rx_n] = cyc;
                bits[0] = tx_out;
                for (int k = 1; k < 20; k++) begin
                    repeat (DIV) @(negedge clk);
                    bits[k] = tx_out;
                end
                w = {bits[18:11], bits[8:1]};
                // R4: frame delimiters, no gap between the bytes
                chk(bits[0] == 1'b0 && bits[9] == 1'b1 && bits[10] == 1'b0 && bits[19] == 1'b1,
                    "R4 framing", {bits[19], bits[10], bits[9], bits[0]}, 4'b1010);
                if (rx_n < exp_n)
                    chk(w == exp_word[rx_n], exp_word[rx_n][15] ? "R3 rst word" : "R2 char word",
                        w, exp_word[rx_n]);
                else
                    chk(1'b0, "R7 unexpected frame", w, 0);
                rx_n++;
            end
        end
    end

    task automatic send_char(input logic [7:0] d, input logic [5:0] f, input bit expect_it);
        char_valid = 1'b1; char_data = d;
        {char_fast, char_pck_pos, char_pps1_pos, char_err, char_start_smp, char_parity} = f;
        if (expect_it) begin
            exp_word[exp_n] = 16'h4000 | (16'(f) << 8) | 16'(d);
            exp_n++;
        end
        @(negedge clk);
        char_valid = 1'b0;
    endtask

    task automatic wait_drain();
        repeat (GAP + 6) @(negedge clk);
    endtask

    initial begin
        int ev, idx;
        // Watchdog
        fork
            begin
                repeat (150000) @(posedge clk);
                if (!finished) begin
                    failures++;
                    $display("FAIL watchdog expired");
                    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                    $finish;
                end
            end
        join_none

        repeat (5) @(negedge clk);
        // R1: idle high during reset
        chk(tx_out == 1'b1, "R1 reset idle", tx_out, 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: idle high after reset, no spurious frame
        chk(tx_out == 1'b1 && rx_n == 0, "R1 post-reset idle", rx_n, 0);

        // R3/R5: rising reset line
        idx = exp_n; ev = cyc;
        sim_rst = 1'b1; exp_word[exp_n] = 16'hC000; exp_n++;
        wait_drain();
        chk(start_cyc[idx] - ev == 2, "R5 latency rst", start_cyc[idx] - ev, 2);

        // R2/R5: sweep every data byte with a spread of flag patterns
        for (int i = 0; i < 256; i++) begin
            idx = exp_n; ev = cyc;
            send_char(8'(i), 6'((i * 37) >> 2), 1'b1);
            wait_drain();
            chk(start_cyc[idx] - ev == 2, "R5 latency char", start_cyc[idx] - ev, 2);
        end

        // R6/R7/R8: burst of five characters then a falling reset line
        idx = exp_n;
        send_char(8'hA1, 6'h01, 1'b1);
        send_char(8'hB2, 6'h22, 1'b1);
        send_char(8'hC3, 6'h13, 1'b1);
        send_char(8'hD4, 6'h3C, 1'b1);
        send_char(8'hE5, 6'h05, 1'b0);   // R7: queue holds DEPTH-1, dropped
        sim_rst = 1'b0; exp_word[exp_n] = 16'h8000; exp_n++;   // R8: last slot
        @(negedge clk);
        repeat (5 * GAP + 10) @(negedge clk);
        for (int k = 1; k < 5; k++)
            chk(start_cyc[idx + k] - start_cyc[idx + k - 1] == GAP, "R6 frame spacing",
                start_cyc[idx + k] - start_cyc[idx + k - 1], GAP);
        chk(rx_n == exp_n, "R7 burst frame count", rx_n, exp_n);

        // R8: reset-line edge and character in the same cycle
        sim_rst = 1'b1; exp_word[exp_n] = 16'hC000; exp_n++;
        send_char(8'h5A, 6'h3F, 1'b0);
        wait_drain();
        chk(rx_n == exp_n, "R8 coincident frame count", rx_n, exp_n);
        chk(tx_out == 1'b1, "R1 idle after traffic", tx_out, 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule